// File: doc/BRIEF.md
# Packed Negative Multiply-Subtract Operand Router

This block sits in front of a row of single-precision fused multiply-add lanes and steers a packed negative multiply-subtract onto them. Three source vectors arrive together with a form byte and a length bit. The form byte picks which source feeds the multiplicand, the multiplier and the subtrahend of every lane. The lanes compute `-(a*b) - c` and return their results and exception flags in the same cycle.

The router collects those lane results and zeroes the upper half of the vector when the short length is selected. It also merges the lane exception flags. The merged result, meant for the destination register (which is also the first source), is registered one cycle after the request. The lane arithmetic itself lives outside the block.

Top module: `fnmsubRouter`

## Requirements
- R1: Form byte 0x9E: in every active lane, multiplicand = destination, multiplier = third source, subtrahend = second source.
- R2: Form byte 0xAE: in every active lane, multiplicand = second source, multiplier = destination, subtrahend = third source.
- R3: Form byte 0xBE: in every active lane, multiplicand = second source, multiplier = third source, subtrahend = destination.
- R4: Lane i uses bits 32*i+31..32*i of every vector port. Result lane i is the result returned by lane i.
- R5: With `isWide`=0, only lanes 0..3 are active. Result bits 255..128 are zero, and the operand ports of lanes 4..7 are driven to zero.
- R6: With `isWide`=1, all eight lanes are active and carry results.
- R7: `excFlags` is the bitwise OR of the flag fields of the active lanes only. Flag bit 4 is invalid, bit 3 denormal, bit 2 overflow, bit 1 underflow and bit 0 precision, both in each lane's 5-bit field and in `excFlags`.
- R8: Any other form byte sets `outIllegal`. The result then equals the destination input unchanged (all 256 bits), `excFlags` is zero, and all lane operand ports are zero.
- R9: `outValid` is high for exactly the cycle after a cycle with `inValid` high. Result, flags and illegal status are registered, and they hold while no request arrives.
- R10: While reset is asserted, `outValid`, `outIllegal`, `result` and `excFlags` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| formByte | input | 8 | Operand form selector |
| isWide | input | 1 | 1 = eight lanes, 0 = four lanes |
| srcDest | input | 256 | Destination / first source vector |
| src2 | input | 256 | Second source vector |
| src3 | input | 256 | Third source vector |
| laneMulA | output | 256 | Multiplicands to the lanes |
| laneMulB | output | 256 | Multipliers to the lanes |
| laneSub | output | 256 | Subtrahends to the lanes |
| laneRes | input | 256 | Results from the lanes (same cycle) |
| laneFlags | input | 40 | Five exception flags per lane |
| outValid | output | 1 | Registered result valid |
| outIllegal | output | 1 | Registered unknown-form indication |
| result | output | 256 | Registered vector for the destination |
| excFlags | output | 5 | Registered merged exception flags |

## Verification
The assertions assume that the lanes are combinational, so `laneRes` and `laneFlags` belong to the operands driven in the same cycle. They also assume that `formByte`, `isWide` and the sources stay stable for the whole request cycle. The bench meets both assumptions with a stand-in lane model built from continuous assignments on the operand ports. It changes inputs only on falling edges. The stand-in makes lanes whose operands are zero report a nonzero flag, so any leak from inactive lanes shows up in the merged flags.

// File: rtl/fnmsubRouterPkg.sv
package fnmsubRouterPkg;
  localparam int NUM_LANES = 8;
  localparam int LANE_W    = 32;
  localparam int FLAG_W    = 5;
  localparam int VEC_W     = NUM_LANES * LANE_W;

  localparam logic [7:0] FORM_BYTE_132 = 8'h9E;
  localparam logic [7:0] FORM_BYTE_213 = 8'hAE;
  localparam logic [7:0] FORM_BYTE_231 = 8'hBE;

  typedef enum logic [1:0] {
    SEL_132  = 2'd0,
    SEL_213  = 2'd1,
    SEL_231  = 2'd2,
    SEL_NONE = 2'd3
  } formSel_e;

  typedef struct packed {
    formSel_e               sel;
    logic [NUM_LANES-1:0]   laneEn;
    logic                   illegal;
    logic                   capture;
  } ctrlStrobe_t;
endpackage

// File: rtl/fnmsubRouterCtrl.sv
module fnmsubRouterCtrl
  import fnmsubRouterPkg::*;
(
  input  logic        inValid,
  input  logic [7:0]  formByte,
  input  logic        isWide,
  output ctrlStrobe_t strobe
);
  localparam int SHORT_LANES = NUM_LANES / 2;

  formSel_e selNext;

  always_comb begin
    case (formByte)
      FORM_BYTE_132: selNext = SEL_132;
      FORM_BYTE_213: selNext = SEL_213;
      FORM_BYTE_231: selNext = SEL_231;
      default:       selNext = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.sel     = selNext;
    strobe.illegal = (selNext == SEL_NONE);
    strobe.capture = inValid;
    for (int i = 0; i < NUM_LANES; i++) begin
      strobe.laneEn[i] = !strobe.illegal && (isWide || (i < SHORT_LANES));
    end
  end
endmodule

// File: rtl/fnmsubRouterDatapath.sv
module fnmsubRouterDatapath
  import fnmsubRouterPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [VEC_W-1:0]            srcDest,
  input  logic [VEC_W-1:0]            src2,
  input  logic [VEC_W-1:0]            src3,
  output logic [VEC_W-1:0]            laneMulA,
  output logic [VEC_W-1:0]            laneMulB,
  output logic [VEC_W-1:0]            laneSub,
  input  logic [VEC_W-1:0]            laneRes,
  input  logic [NUM_LANES*FLAG_W-1:0] laneFlags,
  output logic                        outValid,
  output logic                        outIllegal,
  output logic [VEC_W-1:0]            result,
  output logic [FLAG_W-1:0]           excFlags
);
  logic [VEC_W-1:0]  resNext;
  logic [FLAG_W-1:0] flagNext;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    localparam int LO = g * LANE_W;
    logic [LANE_W-1:0] dW, s2W, s3W;
    assign dW  = srcDest[LO +: LANE_W];
    assign s2W = src2[LO +: LANE_W];
    assign s3W = src3[LO +: LANE_W];

    always_comb begin
      laneMulA[LO +: LANE_W] = '0;
      laneMulB[LO +: LANE_W] = '0;
      laneSub[LO +: LANE_W]  = '0;
      if (strobe.laneEn[g]) begin
        case (strobe.sel)
          SEL_132: begin
            laneMulA[LO +: LANE_W] = dW;
            laneMulB[LO +: LANE_W] = s3W;
            laneSub[LO +: LANE_W]  = s2W;
          end
          SEL_213: begin
            laneMulA[LO +: LANE_W] = s2W;
            laneMulB[LO +: LANE_W] = dW;
            laneSub[LO +: LANE_W]  = s3W;
          end
          SEL_231: begin
            laneMulA[LO +: LANE_W] = s2W;
            laneMulB[LO +: LANE_W] = s3W;
            laneSub[LO +: LANE_W]  = dW;
          end
          default: ;
        endcase
      end
    end

    assign resNext[LO +: LANE_W] = strobe.illegal ? dW :
                                   (strobe.laneEn[g] ? laneRes[LO +: LANE_W] : '0);
  end

  always_comb begin
    flagNext = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (strobe.laneEn[i]) flagNext |= laneFlags[i*FLAG_W +: FLAG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
      result     <= '0;
      excFlags   <= '0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        outIllegal <= strobe.illegal;
        result     <= resNext;
        excFlags   <= flagNext;
      end
    end
  end
endmodule

// File: rtl/fnmsubRouter.sv
module fnmsubRouter
  import fnmsubRouterPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [7:0]                  formByte,
  input  logic                        isWide,
  input  logic [VEC_W-1:0]            srcDest,
  input  logic [VEC_W-1:0]            src2,
  input  logic [VEC_W-1:0]            src3,
  output logic [VEC_W-1:0]            laneMulA,
  output logic [VEC_W-1:0]            laneMulB,
  output logic [VEC_W-1:0]            laneSub,
  input  logic [VEC_W-1:0]            laneRes,
  input  logic [NUM_LANES*FLAG_W-1:0] laneFlags,
  output logic                        outValid,
  output logic                        outIllegal,
  output logic [VEC_W-1:0]            result,
  output logic [FLAG_W-1:0]           excFlags
);
  ctrlStrobe_t strobe;

  fnmsubRouterCtrl ctrl_i (
    .inValid (inValid),
    .formByte(formByte),
    .isWide  (isWide),
    .strobe  (strobe)
  );

  fnmsubRouterDatapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .srcDest   (srcDest),
    .src2      (src2),
    .src3      (src3),
    .laneMulA  (laneMulA),
    .laneMulB  (laneMulB),
    .laneSub   (laneSub),
    .laneRes   (laneRes),
    .laneFlags (laneFlags),
    .outValid  (outValid),
    .outIllegal(outIllegal),
    .result    (result),
    .excFlags  (excFlags)
  );
endmodule

// File: rtl/fnmsubRouterChk.sv
module fnmsubRouterChk
  import fnmsubRouterPkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        inValid,
  input logic [7:0]                  formByte,
  input logic                        isWide,
  input logic [VEC_W-1:0]            srcDest,
  input logic [VEC_W-1:0]            src2,
  input logic [VEC_W-1:0]            src3,
  input logic [VEC_W-1:0]            laneMulA,
  input logic [VEC_W-1:0]            laneMulB,
  input logic [VEC_W-1:0]            laneSub,
  input logic [VEC_W-1:0]            laneRes,
  input logic [NUM_LANES*FLAG_W-1:0] laneFlags,
  input logic                        outValid,
  input logic                        outIllegal,
  input logic [VEC_W-1:0]            result,
  input logic [FLAG_W-1:0]           excFlags
);
  localparam int HALF = VEC_W / 2;

  logic knownForm;
  assign knownForm = (formByte == FORM_BYTE_132) || (formByte == FORM_BYTE_213) ||
                     (formByte == FORM_BYTE_231);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result) && $stable(excFlags));
  a_r5_upper_result_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isWide && knownForm) |=> (result[VEC_W-1:HALF] == '0));
  a_r5_upper_ops_zero: assert property (@(posedge clk) disable iff (!rstN)
    !isWide |-> (laneMulA[VEC_W-1:HALF] == '0) && (laneSub[VEC_W-1:HALF] == '0));
  a_r8_illegal_keeps_dest: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !knownForm) |=> outIllegal && (result == $past(srcDest)) && (excFlags == '0));
  a_r3_sub_from_dest: assert property (@(posedge clk) disable iff (!rstN)
    (formByte == FORM_BYTE_231) |-> (laneSub[LANE_W-1:0] == srcDest[LANE_W-1:0]));
  a_r1_mul_from_dest: assert property (@(posedge clk) disable iff (!rstN)
    (formByte == FORM_BYTE_132) |-> (laneMulA[LANE_W-1:0] == srcDest[LANE_W-1:0]));
endmodule

bind fnmsubRouter fnmsubRouterChk chk_i (.*);

// File: tb/fnmsubRouter_tb_top.sv
`timescale 1ns/1ps
module fnmsubRouter_tb_top;
  import fnmsubRouterPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] formByte = 8'h00;
  logic isWide = 1'b0;
  logic [VEC_W-1:0] srcDest = '0, src2 = '0, src3 = '0;
  logic [VEC_W-1:0] laneMulA, laneMulB, laneSub, laneRes;
  logic [NUM_LANES*FLAG_W-1:0] laneFlags;
  logic outValid, outIllegal;
  logic [VEC_W-1:0] result;
  logic [FLAG_W-1:0] excFlags;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  fnmsubRouter dut_i (.*);

  // stand-in lane model: zero operands still raise flag bit 4
  function automatic logic [LANE_W-1:0] fakeRes(logic [LANE_W-1:0] a, b, c);
    return (a * 32'd3) ^ (b * 32'd5) ^ ~c;
  endfunction
  function automatic logic [FLAG_W-1:0] fakeFlag(logic [LANE_W-1:0] a, b, c);
    return (a[4:0] & b[4:0]) ^ c[4:0] ^ 5'h10;
  endfunction

  for (genvar g = 0; g < NUM_LANES; g++) begin : gStand
    assign laneRes[g*LANE_W +: LANE_W] = fakeRes(laneMulA[g*LANE_W +: LANE_W],
      laneMulB[g*LANE_W +: LANE_W], laneSub[g*LANE_W +: LANE_W]);
    assign laneFlags[g*FLAG_W +: FLAG_W] = fakeFlag(laneMulA[g*LANE_W +: LANE_W],
      laneMulB[g*LANE_W +: LANE_W], laneSub[g*LANE_W +: LANE_W]);
  end

  function automatic logic [VEC_W-1:0] mkVec(logic [31:0] seed, int k);
    logic [VEC_W-1:0] v;
    for (int i = 0; i < NUM_LANES; i++)
      v[i*LANE_W +: LANE_W] = (seed + 32'(k * 8 + i + 1)) * 32'h9E3779B1 ^ (seed << (i + k));
    return v;
  endfunction

  // expected values from the requirements
  logic [VEC_W-1:0] eA, eB, eC, eRes;
  logic [FLAG_W-1:0] eFlags;
  logic eIll;

  task automatic model(input logic [7:0] fb, input logic w);
    eA = '0; eB = '0; eC = '0; eRes = '0; eFlags = '0;
    eIll = !(fb == 8'h9E || fb == 8'hAE || fb == 8'hBE);
    for (int i = 0; i < NUM_LANES; i++) begin
      logic [LANE_W-1:0] d, s2, s3, a, b, c;
      d = srcDest[i*LANE_W +: LANE_W]; s2 = src2[i*LANE_W +: LANE_W]; s3 = src3[i*LANE_W +: LANE_W];
      a = '0; b = '0; c = '0;
      if (fb == 8'h9E) begin a = d;  b = s3; c = s2; end
      if (fb == 8'hAE) begin a = s2; b = d;  c = s3; end
      if (fb == 8'hBE) begin a = s2; b = s3; c = d;  end
      if (!eIll && (w || i < 4)) begin
        eA[i*LANE_W +: LANE_W] = a; eB[i*LANE_W +: LANE_W] = b; eC[i*LANE_W +: LANE_W] = c;
        eRes[i*LANE_W +: LANE_W] = fakeRes(a, b, c);
        eFlags |= fakeFlag(a, b, c);
      end
    end
    if (eIll) eRes = srcDest;
  endtask

  task automatic check(input string req, input string what, input logic [VEC_W-1:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(logic [7:0] fb, logic w);
    if (fb == 8'h9E) return w ? "R1/R6" : "R1/R5";
    if (fb == 8'hAE) return w ? "R2/R6" : "R2/R5";
    if (fb == 8'hBE) return w ? "R3/R6" : "R3/R5";
    return "R8";
  endfunction

  // form byte, wide bit, seed
  localparam logic [40:0] TBL [10] = '{
    {8'h9E, 1'b1, 32'h0000_1234}, {8'hAE, 1'b1, 32'h00C0_FFEE},
    {8'hBE, 1'b1, 32'h0BAD_F00D}, {8'h9E, 1'b0, 32'h1357_9BDF},
    {8'hAE, 1'b0, 32'h2468_ACE0}, {8'hBE, 1'b0, 32'h7777_0001},
    {8'h9F, 1'b1, 32'h5555_AAAA}, {8'h00, 1'b0, 32'h0F0F_0F0F},
    {8'hBE, 1'b1, 32'h0000_0000}, {8'h9E, 1'b1, 32'hFFFF_FFFF}
  };

  task automatic finishRun;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    srcDest = mkVec(32'hDEAD, 0); src2 = mkVec(32'hBEEF, 1); src3 = mkVec(32'hCAFE, 2);
    formByte = 8'h9E; inValid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state even with a request pending
    check("R10", "outValid", VEC_W'(outValid), '0);
    check("R10", "outIllegal", VEC_W'(outIllegal), '0);
    check("R10", "result", result, '0);
    check("R10", "excFlags", VEC_W'(excFlags), '0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    foreach (TBL[t]) begin
      logic [7:0] fb;
      logic w;
      logic [31:0] sd;
      string rq;
      {fb, w, sd} = TBL[t];
      rq = reqOf(fb, w);
      formByte = fb; isWide = w;
      srcDest = mkVec(sd, 0); src2 = mkVec(sd, 1); src3 = mkVec(sd, 2);
      inValid = 1'b1;
      model(fb, w);
      #1;
      check(rq, "laneMulA (R4)", laneMulA, eA);
      check(rq, "laneMulB (R4)", laneMulB, eB);
      check(rq, "laneSub (R4)", laneSub, eC);
      @(negedge clk);
      inValid = 1'b0;
      check("R9", "outValid after request", VEC_W'(outValid), VEC_W'(1));
      check(rq, "result (R4)", result, eRes);
      check(eIll ? "R8" : "R7", "excFlags", VEC_W'(excFlags), VEC_W'(eFlags));
      check("R8", "outIllegal", VEC_W'(outIllegal), VEC_W'(eIll));
      // change inputs without a request: outputs hold
      srcDest = ~srcDest; formByte = 8'hBE; isWide = ~w;
      @(negedge clk);
      check("R9", "outValid idle", VEC_W'(outValid), '0);
      check("R9", "result held", result, eRes);
      check("R9", "flags held", VEC_W'(excFlags), VEC_W'(eFlags));
    end

    // R9: back-to-back requests give valid on consecutive cycles
    formByte = 8'hAE; isWide = 1'b1; inValid = 1'b1;
    srcDest = mkVec(32'h42, 3); src2 = mkVec(32'h43, 4); src3 = mkVec(32'h44, 5);
    @(negedge clk);
    check("R9", "back-to-back first", VEC_W'(outValid), VEC_W'(1));
    formByte = 8'h9E; isWide = 1'b0;
    model(8'h9E, 1'b0);
    @(negedge clk);
    inValid = 1'b0;
    check("R9", "back-to-back second", VEC_W'(outValid), VEC_W'(1));
    check("R5", "short result upper zero", result, eRes);
    check("R7", "short flags", VEC_W'(excFlags), VEC_W'(eFlags));
    @(negedge clk);
    check("R9", "drop after burst", VEC_W'(outValid), '0);

    finishRun();
  end
endmodule